// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block carries out the entry sequence when a 32-bit RISC core with branch delay slots takes an exception or an interrupt. The core presents a pending synchronous exception (a valid strobe plus an index), two level-sensitive interrupt requests (external and tick timer), the PC of the faulting or interrupted instruction, and a flag saying whether that instruction sits in a delay slot. The block owns the supervision register, the saved-status register, the exception PC, the exception effective address and the load-linked reservation address. The core may also write the supervision register and the reservation address directly.

A three-state machine runs the sequence. ST_IDLE waits for a request. On the edge that accepts one, it latches the chosen index, the PC and the delay-slot flag. It then moves to ST_ENTER if the index names a defined exception, or to ST_FAULT if it does not. ST_ENTER is the single entry cycle. In that cycle the block pulses the entry strobe, drives the vector as a fetch redirect, and requests a TLB flush and an MMU bypass. At the end of the cycle it commits every saved register. ST_FAULT lasts one cycle and reports an unhandled exception without touching any register. Both states return to ST_IDLE, so the pending index falls back to "none" after each entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, the exception PC receives the latched PC. If the delay-slot flag was set, it receives the PC minus 4, status bit 5 (delay-slot exception) becomes 1, and `dslot_clr_o` pulses during the entry cycle. Otherwise bit 5 becomes 0 and `dslot_clr_o` stays low.
- R2: For a system call (index 12), the exception PC is 4 higher than the value R1 gives.
- R3: For an illegal instruction (index 7), the exception effective address receives the latched PC. Every other exception leaves it unchanged.
- R4: The saved status receives the whole supervision register as it stood before the entry.
- R5: On entry, the supervision register clears bits 1 (interrupt enable), 2 (tick enable), 3 (data MMU enable) and 4 (instruction MMU enable), and sets bit 0 (supervisor mode). Its other bits are kept.
- R6: The redirect carries the index shifted left by 8. `entry_o` and `redirect_valid_o` are high for exactly the one cycle after the accepting edge.
- R7: An index of 0, or one of 15 or above, makes `unhandled_o` pulse for one cycle. There is no redirect, and all saved registers and the supervision register stay unchanged.
- R8: The external interrupt (index 8) is taken only while bit 1 is set, and the timer interrupt (index 5) only while bit 2 is set. When both are taken in the same cycle, the timer wins. A disabled interrupt causes no entry and changes no register.
- R9: A valid synchronous exception beats an interrupt request that arrives in the same cycle.
- R10: Entry sets the reservation address to all ones, and `tlb_flush_o` and `mmu_bypass_o` are high during the entry cycle.
- R11: After the active-low synchronous reset, the supervision register reads 0x0001 and the saved status, exception PC, effective address and reservation address read 0. No strobe output is active.
- R12: Outside entry, `sr_we_i` loads the supervision register and `ll_we_i` loads the reservation address on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_idx_i | input | 5 | Index of the pending exception |
| ext_irq_i | input | 1 | External interrupt request |
| tmr_irq_i | input | 1 | Tick timer interrupt request |
| pc_i | input | 32 | PC of the current instruction |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| sr_we_i | input | 1 | Supervision register write enable |
| sr_wdata_i | input | 16 | Supervision register write data |
| ll_we_i | input | 1 | Reservation address write enable |
| ll_addr_i | input | 32 | Reservation address write data |
| entry_o | output | 1 | Entry cycle strobe |
| redirect_valid_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | 32 | Vector address |
| unhandled_o | output | 1 | Unhandled exception index |
| dslot_clr_o | output | 1 | Clear the core's delay-slot flag |
| tlb_flush_o | output | 1 | TLB flush request |
| mmu_bypass_o | output | 1 | MMU translation bypass |
| sr_o | output | 16 | Supervision register |
| esr_o | output | 16 | Saved status |
| epcr_o | output | 32 | Exception PC |
| eear_o | output | 32 | Exception effective address |
| ll_addr_o | output | 32 | Reservation address |

## Verification
A request is sampled on a rising edge. `entry_o`, `redirect_valid_o`, `redirect_pc_o`, `dslot_clr_o`, `tlb_flush_o`, `mmu_bypass_o` and `unhandled_o` are then valid for the whole following cycle. The saved registers, the supervision register and the reservation address change one edge later. The driver applies stimulus just after a falling edge and holds it for one cycle. It pushes the expected result into a queue. The monitor samples on falling edges: it checks the strobes and the redirect on the first falling edge where `entry_o` or `unhandled_o` is high, and the register values on the next falling edge. When a request should be ignored, the bench waits three cycles and then checks that no strobe appeared and that the registers are unchanged.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN      = 32;
    localparam int SR_W      = 16;
    localparam int IDX_W     = 5;
    localparam int EXC_COUNT = 15;
    localparam int VEC_SHIFT = 8;

    // supervision register bit positions
    localparam int SR_SUP    = 0;
    localparam int SR_IRQ_EN = 1;
    localparam int SR_TMR_EN = 2;
    localparam int SR_DMMU   = 3;
    localparam int SR_IMMU   = 4;
    localparam int SR_DSX    = 5;

    // exception indices
    localparam int IDX_TICK    = 5;
    localparam int IDX_ILLEGAL = 7;
    localparam int IDX_EXT     = 8;
    localparam int IDX_SYSCALL = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTER = 2'd1,
        ST_FAULT = 2'd2
    } entry_state_e;

endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb #(
    parameter int IDX_W     = 5,
    parameter int EXC_COUNT = 15,
    parameter int IDX_TICK  = 5,
    parameter int IDX_EXT   = 8
) (
    input  logic             exc_valid_i,
    input  logic [IDX_W-1:0] exc_idx_i,
    input  logic             ext_irq_i,
    input  logic             tmr_irq_i,
    input  logic             irq_en_i,
    input  logic             tmr_en_i,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             idx_ok_o
);
    logic ext_take;
    logic tmr_take;

    assign ext_take = ext_irq_i & irq_en_i;
    assign tmr_take = tmr_irq_i & tmr_en_i;

    // synchronous exception first, then timer, then external
    always_comb begin
        if (exc_valid_i)   idx_o = exc_idx_i;
        else if (tmr_take) idx_o = IDX_W'(IDX_TICK);
        else if (ext_take) idx_o = IDX_W'(IDX_EXT);
        else               idx_o = '0;
    end

    assign req_o    = exc_valid_i | tmr_take | ext_take;
    assign idx_ok_o = (idx_o != '0) && (int'(idx_o) < EXC_COUNT);

endmodule

// File: rtl/exc_entry_addr.sv
module exc_entry_addr #(
    parameter int XLEN        = 32,
    parameter int IDX_W       = 5,
    parameter int VEC_SHIFT   = 8,
    parameter int IDX_SYSCALL = 12,
    parameter int IDX_ILLEGAL = 7
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic             dslot_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [XLEN-1:0]  epc_o,
    output logic [XLEN-1:0]  vec_o,
    output logic             illegal_o
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic            is_syscall;
    logic [XLEN-1:0] slot_adj;

    assign is_syscall = (idx_i == IDX_W'(IDX_SYSCALL));
    assign illegal_o  = (idx_i == IDX_W'(IDX_ILLEGAL));

    assign slot_adj = dslot_i ? (pc_i - INSN_BYTES) : pc_i;
    assign epc_o    = is_syscall ? (slot_adj + INSN_BYTES) : slot_adj;
    assign vec_o    = XLEN'(idx_i) << VEC_SHIFT;

endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs #(
    parameter int XLEN      = 32,
    parameter int SR_W      = 16,
    parameter int SR_SUP    = 0,
    parameter int SR_IRQ_EN = 1,
    parameter int SR_TMR_EN = 2,
    parameter int SR_DMMU   = 3,
    parameter int SR_IMMU   = 4,
    parameter int SR_DSX    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_i,
    input  logic            dslot_i,
    input  logic            illegal_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            sr_we_i,
    input  logic [SR_W-1:0] sr_wdata_i,
    input  logic            ll_we_i,
    input  logic [XLEN-1:0] ll_addr_i,
    output logic [SR_W-1:0] sr_o,
    output logic [SR_W-1:0] esr_o,
    output logic [XLEN-1:0] epcr_o,
    output logic [XLEN-1:0] eear_o,
    output logic [XLEN-1:0] ll_addr_o
);
    localparam logic [SR_W-1:0] SR_RST = SR_W'(1) << SR_SUP;

    logic [SR_W-1:0] sr_q, esr_q, sr_entry;
    logic [XLEN-1:0] epcr_q, eear_q, ll_q;

    always_comb begin
        sr_entry            = sr_q;
        sr_entry[SR_IRQ_EN] = 1'b0;
        sr_entry[SR_TMR_EN] = 1'b0;
        sr_entry[SR_DMMU]   = 1'b0;
        sr_entry[SR_IMMU]   = 1'b0;
        sr_entry[SR_SUP]    = 1'b1;
        sr_entry[SR_DSX]    = dslot_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= SR_RST;
            esr_q  <= '0;
            epcr_q <= '0;
            eear_q <= '0;
            ll_q   <= '0;
        end else if (enter_i) begin
            sr_q   <= sr_entry;
            esr_q  <= sr_q;
            epcr_q <= epc_i;
            if (illegal_i) eear_q <= pc_i;
            ll_q   <= '1;
        end else begin
            if (sr_we_i) sr_q <= sr_wdata_i;
            if (ll_we_i) ll_q <= ll_addr_i;
        end
    end

    assign sr_o      = sr_q;
    assign esr_o     = esr_q;
    assign epcr_o    = epcr_q;
    assign eear_o    = eear_q;
    assign ll_addr_o = ll_q;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int P_XLEN      = XLEN,
    parameter int P_SR_W      = SR_W,
    parameter int P_IDX_W     = IDX_W,
    parameter int P_EXC_COUNT = EXC_COUNT,
    parameter int P_VEC_SHIFT = VEC_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_valid_i,
    input  logic [P_IDX_W-1:0]   exc_idx_i,
    input  logic                 ext_irq_i,
    input  logic                 tmr_irq_i,
    input  logic [P_XLEN-1:0]    pc_i,
    input  logic                 dslot_i,
    input  logic                 sr_we_i,
    input  logic [P_SR_W-1:0]    sr_wdata_i,
    input  logic                 ll_we_i,
    input  logic [P_XLEN-1:0]    ll_addr_i,
    output logic                 entry_o,
    output logic                 redirect_valid_o,
    output logic [P_XLEN-1:0]    redirect_pc_o,
    output logic                 unhandled_o,
    output logic                 dslot_clr_o,
    output logic                 tlb_flush_o,
    output logic                 mmu_bypass_o,
    output logic [P_SR_W-1:0]    sr_o,
    output logic [P_SR_W-1:0]    esr_o,
    output logic [P_XLEN-1:0]    epcr_o,
    output logic [P_XLEN-1:0]    eear_o,
    output logic [P_XLEN-1:0]    ll_addr_o
);
    entry_state_e       state_q, state_d;
    logic [P_IDX_W-1:0] pend_idx_q;
    logic [P_XLEN-1:0]  pc_q;
    logic               dslot_q;

    logic               req;
    logic [P_IDX_W-1:0] sel_idx;
    logic               sel_ok;
    logic [P_XLEN-1:0]  epc;
    logic [P_XLEN-1:0]  vec;
    logic               is_illegal;
    logic               enter;

    exc_entry_arb #(
        .IDX_W     (P_IDX_W),
        .EXC_COUNT (P_EXC_COUNT),
        .IDX_TICK  (IDX_TICK),
        .IDX_EXT   (IDX_EXT)
    ) u_arb (
        .exc_valid_i (exc_valid_i),
        .exc_idx_i   (exc_idx_i),
        .ext_irq_i   (ext_irq_i),
        .tmr_irq_i   (tmr_irq_i),
        .irq_en_i    (sr_o[SR_IRQ_EN]),
        .tmr_en_i    (sr_o[SR_TMR_EN]),
        .req_o       (req),
        .idx_o       (sel_idx),
        .idx_ok_o    (sel_ok)
    );

    exc_entry_addr #(
        .XLEN        (P_XLEN),
        .IDX_W       (P_IDX_W),
        .VEC_SHIFT   (P_VEC_SHIFT),
        .IDX_SYSCALL (IDX_SYSCALL),
        .IDX_ILLEGAL (IDX_ILLEGAL)
    ) u_addr (
        .pc_i      (pc_q),
        .dslot_i   (dslot_q),
        .idx_i     (pend_idx_q),
        .epc_o     (epc),
        .vec_o     (vec),
        .illegal_o (is_illegal)
    );

    exc_entry_regs #(
        .XLEN      (P_XLEN),
        .SR_W      (P_SR_W),
        .SR_SUP    (SR_SUP),
        .SR_IRQ_EN (SR_IRQ_EN),
        .SR_TMR_EN (SR_TMR_EN),
        .SR_DMMU   (SR_DMMU),
        .SR_IMMU   (SR_IMMU),
        .SR_DSX    (SR_DSX)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (enter),
        .dslot_i    (dslot_q),
        .illegal_i  (is_illegal),
        .epc_i      (epc),
        .pc_i       (pc_q),
        .sr_we_i    (sr_we_i),
        .sr_wdata_i (sr_wdata_i),
        .ll_we_i    (ll_we_i),
        .ll_addr_i  (ll_addr_i),
        .sr_o       (sr_o),
        .esr_o      (esr_o),
        .epcr_o     (epcr_o),
        .eear_o     (eear_o),
        .ll_addr_o  (ll_addr_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // snapshot of the accepted request; cleared back to "none" on return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx_q <= '0;
            pc_q       <= '0;
            dslot_q    <= 1'b0;
        end else if (state_q == ST_IDLE && req) begin
            pend_idx_q <= sel_idx;
            pc_q       <= pc_i;
            dslot_q    <= dslot_i;
        end else if (state_q != ST_IDLE) begin
            pend_idx_q <= '0;
            dslot_q    <= 1'b0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = sel_ok ? ST_ENTER : ST_FAULT;
            ST_ENTER: state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        enter            = 1'b0;
        redirect_valid_o = 1'b0;
        unhandled_o      = 1'b0;
        dslot_clr_o      = 1'b0;
        tlb_flush_o      = 1'b0;
        mmu_bypass_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ENTER: begin
                enter            = 1'b1;
                redirect_valid_o = 1'b1;
                dslot_clr_o      = dslot_q;
                tlb_flush_o      = 1'b1;
                mmu_bypass_o     = 1'b1;
            end
            ST_FAULT: unhandled_o = 1'b1;
            default: ;
        endcase
    end

    assign entry_o       = enter;
    assign redirect_pc_o = redirect_valid_o ? vec : '0;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int P_XLEN      = XLEN,
    parameter int P_SR_W      = SR_W,
    parameter int P_VEC_SHIFT = VEC_SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              entry_o,
    input logic              redirect_valid_o,
    input logic [P_XLEN-1:0] redirect_pc_o,
    input logic              unhandled_o,
    input logic              tlb_flush_o,
    input logic              mmu_bypass_o,
    input logic [P_SR_W-1:0] sr_o,
    input logic [P_SR_W-1:0] esr_o,
    input logic [P_XLEN-1:0] epcr_o,
    input logic [P_XLEN-1:0] ll_addr_o
);
    localparam logic [P_XLEN-1:0] VEC_MASK = (P_XLEN'(1) << P_VEC_SHIFT) - P_XLEN'(1);

    assert_entry_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> !entry_o);

    assert_vec_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> ((redirect_pc_o & VEC_MASK) == '0));

    assert_sr_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> (sr_o[SR_SUP] && !sr_o[SR_IRQ_EN] && !sr_o[SR_TMR_EN]
                     && !sr_o[SR_DMMU] && !sr_o[SR_IMMU]));

    assert_esr_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> (esr_o == $past(sr_o)));

    assert_ll_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> (&ll_addr_o));

    assert_flush_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (tlb_flush_o && mmu_bypass_o));

    assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled_o |=> (epcr_o == $past(epcr_o) && sr_o == $past(sr_o)));

    assert_fault_noredir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled_o |-> (!redirect_valid_o && !entry_o));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .P_XLEN      (P_XLEN),
    .P_SR_W      (P_SR_W),
    .P_VEC_SHIFT (P_VEC_SHIFT)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .entry_o          (entry_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .unhandled_o      (unhandled_o),
    .tlb_flush_o      (tlb_flush_o),
    .mmu_bypass_o     (mmu_bypass_o),
    .sr_o             (sr_o),
    .esr_o            (esr_o),
    .epcr_o           (epcr_o),
    .ll_addr_o        (ll_addr_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [4:0]  exc_idx_i = '0;
    logic        ext_irq_i = 1'b0;
    logic        tmr_irq_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        dslot_i = 1'b0;
    logic        sr_we_i = 1'b0;
    logic [15:0] sr_wdata_i = '0;
    logic        ll_we_i = 1'b0;
    logic [31:0] ll_addr_i = '0;
    logic        entry_o, redirect_valid_o, unhandled_o, dslot_clr_o;
    logic        tlb_flush_o, mmu_bypass_o;
    logic [31:0] redirect_pc_o, epcr_o, eear_o, ll_addr_o;
    logic [15:0] sr_o, esr_o;

    always #2 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_idx_i(exc_idx_i),
        .ext_irq_i(ext_irq_i), .tmr_irq_i(tmr_irq_i), .pc_i(pc_i), .dslot_i(dslot_i),
        .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .ll_we_i(ll_we_i), .ll_addr_i(ll_addr_i),
        .entry_o(entry_o), .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .unhandled_o(unhandled_o), .dslot_clr_o(dslot_clr_o), .tlb_flush_o(tlb_flush_o),
        .mmu_bypass_o(mmu_bypass_o), .sr_o(sr_o), .esr_o(esr_o), .epcr_o(epcr_o),
        .eear_o(eear_o), .ll_addr_o(ll_addr_o)
    );

    typedef struct {
        string       tag;
        logic        bad;
        logic        dclr;
        logic [31:0] vec;
        logic [31:0] epcr;
        logic [31:0] eear;
        logic [31:0] ll;
        logic [15:0] esr;
        logic [15:0] sr;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;

    // bench model of the architectural registers
    logic [15:0] m_sr   = 16'h0001;
    logic [15:0] m_esr  = '0;
    logic [31:0] m_epcr = '0;
    logic [31:0] m_eear = '0;
    logic [31:0] m_ll   = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: strobes in the entry cycle, registers one cycle later
    always begin
        @(negedge clk);
        if (rst_n && (entry_o || unhandled_o)) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected entry", {31'd0, entry_o | unhandled_o}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " unhandled"},  {31'd0, unhandled_o}, {31'd0, e.bad});
                chk({e.tag, " R6 redir"},   {31'd0, redirect_valid_o}, {31'd0, !e.bad});
                chk({e.tag, " R6 vector"},  redirect_pc_o, e.bad ? 32'd0 : e.vec);
                chk({e.tag, " R1 dslot"},   {31'd0, dslot_clr_o}, {31'd0, e.dclr});
                chk({e.tag, " R10 flush"},  {30'd0, tlb_flush_o, mmu_bypass_o},
                                            e.bad ? 32'd0 : 32'd3);
                @(negedge clk);
                chk({e.tag, " epcr"},       epcr_o, e.epcr);
                chk({e.tag, " R3 eear"},    eear_o, e.eear);
                chk({e.tag, " R4 esr"},     {16'd0, esr_o}, {16'd0, e.esr});
                chk({e.tag, " R5 sr"},      {16'd0, sr_o}, {16'd0, e.sr});
                chk({e.tag, " R10 ll"},     ll_addr_o, e.ll);
                chk({e.tag, " R6 pulse"},   {31'd0, entry_o}, 32'd0);
            end
        end
    end

    task automatic write_sr(input logic [15:0] v);
        sr_we_i = 1'b1; sr_wdata_i = v;
        @(negedge clk);
        sr_we_i = 1'b0;
        m_sr = v;
        chk("R12 sr write", {16'd0, sr_o}, {16'd0, v});
    endtask

    task automatic write_ll(input logic [31:0] v);
        ll_we_i = 1'b1; ll_addr_i = v;
        @(negedge clk);
        ll_we_i = 1'b0;
        m_ll = v;
        chk("R12 ll write", ll_addr_o, v);
    endtask

    // driver: computes the expected outcome, pushes it, applies the stimulus
    task automatic fire(input string tag, input logic v, input logic [4:0] idx,
                        input logic ext, input logic tmr,
                        input logic [31:0] pc, input logic ds);
        int   sel;
        exp_t e;
        sel = -1;
        if (v)                   sel = idx;
        else if (tmr && m_sr[2]) sel = 5;
        else if (ext && m_sr[1]) sel = 8;
        if (sel >= 0) begin
            e.tag = tag;
            e.bad = (sel == 0) || (sel >= 15);
            e.vec = 32'(sel) << 8;
            if (e.bad) begin
                e.dclr = 1'b0;
            end else begin
                e.dclr = ds;
                m_esr  = m_sr;
                m_epcr = pc - (ds ? 32'd4 : 32'd0) + ((sel == 12) ? 32'd4 : 32'd0);
                if (sel == 7) m_eear = pc;
                m_sr   = (m_sr & ~16'h003E) | 16'h0001 | (ds ? 16'h0020 : 16'h0000);
                m_ll   = '1;
            end
            e.epcr = m_epcr; e.eear = m_eear; e.esr = m_esr; e.sr = m_sr; e.ll = m_ll;
            exp_q.push_back(e);
        end
        exc_valid_i = v; exc_idx_i = idx; ext_irq_i = ext; tmr_irq_i = tmr;
        pc_i = pc; dslot_i = ds;
        @(negedge clk);
        exc_valid_i = 1'b0; exc_idx_i = '0; ext_irq_i = 1'b0; tmr_irq_i = 1'b0;
        dslot_i = 1'b0;
        repeat (3) @(negedge clk);
        if (sel < 0) begin
            chk({tag, " R8 ignored sr"},   {16'd0, sr_o}, {16'd0, m_sr});
            chk({tag, " R8 ignored epcr"}, epcr_o, m_epcr);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 sr",   {16'd0, sr_o}, 32'h0001);
        chk("R11 esr",  {16'd0, esr_o}, 32'd0);
        chk("R11 epcr", epcr_o, 32'd0);
        chk("R11 eear", eear_o, 32'd0);
        chk("R11 ll",   ll_addr_o, 32'd0);
        chk("R11 strobes", {28'd0, entry_o, redirect_valid_o, unhandled_o, tlb_flush_o}, 32'd0);

        write_sr(16'h001F);                                                    // R12
        fire("R2 syscall", 1'b1, 5'd12, 1'b0, 1'b0, 32'h0000_1000, 1'b0);
        write_sr(16'h001F);
        fire("R1 R3 illegal dslot", 1'b1, 5'd7, 1'b0, 1'b0, 32'h0000_2008, 1'b1);
        fire("R1 R2 syscall dslot", 1'b1, 5'd12, 1'b0, 1'b0, 32'h0000_3004, 1'b1);
        write_ll(32'h0000_0040);
        fire("R10 ll clear", 1'b1, 5'd3, 1'b0, 1'b0, 32'h0000_4000, 1'b0);
        write_sr(16'h0001);
        fire("R8 ext disabled", 1'b0, 5'd0, 1'b1, 1'b0, 32'h0000_5000, 1'b0);
        fire("R8 tmr disabled", 1'b0, 5'd0, 1'b0, 1'b1, 32'h0000_5004, 1'b0);
        write_sr(16'h0003);
        fire("R8 ext taken", 1'b0, 5'd0, 1'b1, 1'b0, 32'h0000_6000, 1'b0);
        write_sr(16'h0007);
        fire("R8 timer wins", 1'b0, 5'd0, 1'b1, 1'b1, 32'h0000_7000, 1'b0);
        write_sr(16'h0107);
        fire("R9 sync beats irq", 1'b1, 5'd7, 1'b1, 1'b1, 32'h0000_8000, 1'b0);
        fire("R7 index zero", 1'b1, 5'd0, 1'b0, 1'b0, 32'h0000_9000, 1'b1);
        fire("R7 index 20", 1'b1, 5'd20, 1'b0, 1'b0, 32'h0000_9004, 1'b0);
        fire("R7 index 15", 1'b1, 5'd15, 1'b0, 1'b0, 32'h0000_9008, 1'b0);
        fire("R6 index 14", 1'b1, 5'd14, 1'b0, 1'b0, 32'h0000_A000, 1'b0);
        repeat (4) @(negedge clk);
        chk("R6 queue drained", 32'(exp_q.size()), 32'd0);
        summary();
    end

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule